// File: doc/BRIEF.md
# SPI FIFO Level, Interrupt and DMA Request Controller

This block keeps the occupancy counts of the transmit and receive FIFOs of an SPI controller and derives every flag that software and the DMA engine see from them. The block does not hold the storage arrays. It sees the push and pop strobes that go to them: the bus side pushes TX words and pops RX words, and the shift engine pops TX words and pushes RX words. From these strobes it tracks both levels. It turns them into a six-bit status word, five interrupt sources (two level-based, three sticky), a masked interrupt vector with one combined interrupt line, and one DMA request line per direction.

Software programs an RX interrupt threshold, a TX and an RX DMA threshold, an interrupt mask and two DMA enable bits. It acknowledges sticky events by writing ones to a clear strobe. When the controller enable is dropped, both FIFOs are flushed in the same cycle. The FIFO depth is a parameter; the usual values are 32 or 64.

Top module: `spi_fifo_flag_ctrl`

## Requirements
- R1: While `enable` is high, an accepted push raises a level by one on the next clock. An accepted pop lowers it by one. A push and a pop that are both accepted in the same cycle leave it unchanged. Each level stays within 0..DEPTH.
- R2: A push to a full FIFO or a pop from an empty FIFO is discarded, and this is decided on the level before the edge. For a simultaneous push and pop on a full FIFO, only the pop is accepted (level DEPTH-1). On an empty FIFO, only the push is accepted (level 1).
- R3: Sticky flags in `rawInt`: bit 1 is TX overflow, set by `txPush` on a full TX FIFO. Bit 3 is RX overflow, set by `rxPush` on a full RX FIFO. Bit 2 is RX underflow, set by `rxPop` on an empty RX FIFO. Each flag is set one clock after the event, only while enabled, and stays set until it is cleared. A `txPop` on an empty TX FIFO sets no flag.
- R4: A cycle with `clrWr` high clears flags by `clrData` bit. Bit 0 clears all three sticky flags, bit 1 clears RX underflow, bit 2 clears RX overflow and bit 3 clears TX overflow. A new event in the same cycle as its own clear leaves the flag set. Clears act whether or not the block is enabled.
- R5: Level-based sources follow the current levels every cycle: `rawInt` bit 0 is high when the TX level is 0, and bit 4 is high when the RX level is strictly greater than `rxThresh`.
- R6: `maskedInt` equals `rawInt` AND `intMask` bit by bit, and `irq` is the OR of `maskedInt`.
- R7: `status` bits: bit 0 busy = `enable` and (`engineBusy` or TX level nonzero), bit 1 TX full, bit 2 TX empty, bit 3 RX empty, bit 4 RX full, bit 5 = `enable` and `slaveTxBusy`.
- R8: `txDmaReq` is high while `enable`, `dmaEn` bit 1 and TX level <= `txDmaThresh`.
- R9: `rxDmaReq` is high while `enable`, `dmaEn` bit 0 and RX level >= `rxDmaThresh` + 1.
- R10: While `enable` is low, both levels are 0 from the next clock on. Pushes and pops change no level and set no sticky flag, and sticky flags already set are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low flushes both FIFOs |
| txPush | input | 1 | Bus writes one TX word |
| txPop | input | 1 | Shift engine takes one TX word |
| rxPush | input | 1 | Shift engine stores one RX word |
| rxPop | input | 1 | Bus reads one RX word |
| engineBusy | input | 1 | Shift engine is mid-frame |
| slaveTxBusy | input | 1 | Target-mode transmitter still shifting |
| clrWr | input | 1 | Write strobe of the clear register |
| clrData | input | 4 | Write-one-to-clear bits |
| rxThresh | input | LVL_W | RX interrupt threshold |
| txDmaThresh | input | LVL_W | TX DMA request threshold |
| rxDmaThresh | input | LVL_W | RX DMA request threshold |
| intMask | input | 5 | Interrupt mask, 1 = pass |
| dmaEn | input | 2 | Bit 0 RX DMA enable, bit 1 TX DMA enable |
| txLevel | output | LVL_W | TX FIFO occupancy |
| rxLevel | output | LVL_W | RX FIFO occupancy |
| status | output | 6 | Status word |
| rawInt | output | 5 | Unmasked interrupt sources |
| maskedInt | output | 5 | Masked interrupt sources |
| irq | output | 1 | Combined interrupt |
| txDmaReq | output | 1 | TX DMA request |
| rxDmaReq | output | 1 | RX DMA request |

## Verification
The properties assume that the strobes and thresholds are synchronous to `clk` and stable around each edge, and that the thresholds hold values of at most DEPTH. They make no assumption about pushes to a full FIFO or pops from an empty one, because those are legal stimulus that must raise flags. The stimulus changes every input only on the falling edge. It sweeps every pair of level and threshold over a small depth, and it deliberately pushes past full, pops past empty and drops the enable while flags are set, so the error paths stay inside the modelled behaviour.

// File: rtl/spiflag_pkg.sv
package spiflag_pkg;

  // Bit positions of the interrupt vector
  localparam int INT_TX_EMPTY = 0;
  localparam int INT_TX_OVF   = 1;
  localparam int INT_RX_UDF   = 2;
  localparam int INT_RX_OVF   = 3;
  localparam int INT_RX_THR   = 4;
  localparam int INT_W        = 5;

  // Bit positions of the status word
  localparam int ST_BUSY      = 0;
  localparam int ST_TX_FULL   = 1;
  localparam int ST_TX_EMPTY  = 2;
  localparam int ST_RX_EMPTY  = 3;
  localparam int ST_RX_FULL   = 4;
  localparam int ST_SLV_BUSY  = 5;
  localparam int ST_W         = 6;

  // Clear register bits
  localparam int CLR_ALL      = 0;
  localparam int CLR_RX_UDF   = 1;
  localparam int CLR_RX_OVF   = 2;
  localparam int CLR_TX_OVF   = 3;
  localparam int CLR_W        = 4;

  // DMA enable bits
  localparam int DMA_RX       = 0;
  localparam int DMA_TX       = 1;

  // Sticky flag indices inside the datapath
  localparam int STK_TX_OVF   = 0;
  localparam int STK_RX_OVF   = 1;
  localparam int STK_RX_UDF   = 2;
  localparam int STK_N        = 3;

  typedef struct packed {
    logic             flush;
    logic             txInc;
    logic             txDec;
    logic             rxInc;
    logic             rxDec;
    logic [STK_N-1:0] stkSet;
    logic [STK_N-1:0] stkClr;
  } fifoStrobes_t;

endpackage

// File: rtl/spiflag_level_cnt.sv
module spiflag_level_cnt #(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inc,
  input  logic             dec,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= '0;
    end else if (flush) begin
      level <= '0;
    end else if (inc && !dec) begin
      level <= level + LVL_W'(1);
    end else if (dec && !inc) begin
      level <= level - LVL_W'(1);
    end
  end

  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);
endmodule

// File: rtl/spiflag_datapath.sv
module spiflag_datapath
  import spiflag_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strb,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             rxEmpty,
  output logic [STK_N-1:0] sticky
);

  spiflag_level_cnt #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_txCnt (
    .clk  (clk),
    .rstN (rstN),
    .flush(strb.flush),
    .inc  (strb.txInc),
    .dec  (strb.txDec),
    .level(txLevel),
    .full (txFull),
    .empty(txEmpty)
  );

  spiflag_level_cnt #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxCnt (
    .clk  (clk),
    .rstN (rstN),
    .flush(strb.flush),
    .inc  (strb.rxInc),
    .dec  (strb.rxDec),
    .level(rxLevel),
    .full (rxFull),
    .empty(rxEmpty)
  );

  // Sticky event flags: a set in the same cycle as a clear wins
  for (genvar g = 0; g < STK_N; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sticky[g] <= 1'b0;
      end else if (strb.stkSet[g]) begin
        sticky[g] <= 1'b1;
      end else if (strb.stkClr[g]) begin
        sticky[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spiflag_ctrl.sv
module spiflag_ctrl
  import spiflag_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             enable,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             engineBusy,
  input  logic             slaveTxBusy,
  input  logic             clrWr,
  input  logic [CLR_W-1:0] clrData,
  input  logic [LVL_W-1:0] rxThresh,
  input  logic [LVL_W-1:0] txDmaThresh,
  input  logic [LVL_W-1:0] rxDmaThresh,
  input  logic [INT_W-1:0] intMask,
  input  logic [1:0]       dmaEn,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             txFull,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             rxEmpty,
  input  logic [STK_N-1:0] sticky,
  output fifoStrobes_t     strb,
  output logic [ST_W-1:0]  status,
  output logic [INT_W-1:0] rawInt,
  output logic [INT_W-1:0] maskedInt,
  output logic             irq,
  output logic             txDmaReq,
  output logic             rxDmaReq
);
  // One extra bit so that threshold + 1 cannot wrap
  logic [LVL_W:0] rxDmaLimit;

  always_comb begin
    strb       = '0;
    strb.flush = !enable;
    strb.txInc = enable && txPush && !txFull;
    strb.txDec = enable && txPop  && !txEmpty;
    strb.rxInc = enable && rxPush && !rxFull;
    strb.rxDec = enable && rxPop  && !rxEmpty;

    strb.stkSet[STK_TX_OVF] = enable && txPush && txFull;
    strb.stkSet[STK_RX_OVF] = enable && rxPush && rxFull;
    strb.stkSet[STK_RX_UDF] = enable && rxPop  && rxEmpty;

    strb.stkClr[STK_TX_OVF] = clrWr && (clrData[CLR_ALL] || clrData[CLR_TX_OVF]);
    strb.stkClr[STK_RX_OVF] = clrWr && (clrData[CLR_ALL] || clrData[CLR_RX_OVF]);
    strb.stkClr[STK_RX_UDF] = clrWr && (clrData[CLR_ALL] || clrData[CLR_RX_UDF]);
  end

  always_comb begin
    status              = '0;
    status[ST_BUSY]     = enable && (engineBusy || !txEmpty);
    status[ST_TX_FULL]  = txFull;
    status[ST_TX_EMPTY] = txEmpty;
    status[ST_RX_EMPTY] = rxEmpty;
    status[ST_RX_FULL]  = rxFull;
    status[ST_SLV_BUSY] = enable && slaveTxBusy;
  end

  always_comb begin
    rawInt               = '0;
    rawInt[INT_TX_EMPTY] = txEmpty;
    rawInt[INT_TX_OVF]   = sticky[STK_TX_OVF];
    rawInt[INT_RX_UDF]   = sticky[STK_RX_UDF];
    rawInt[INT_RX_OVF]   = sticky[STK_RX_OVF];
    rawInt[INT_RX_THR]   = (rxLevel > rxThresh);
  end

  assign maskedInt  = rawInt & intMask;
  assign irq        = |maskedInt;

  assign rxDmaLimit = {1'b0, rxDmaThresh} + (LVL_W + 1)'(1);
  assign txDmaReq   = enable && dmaEn[DMA_TX] && (txLevel <= txDmaThresh);
  assign rxDmaReq   = enable && dmaEn[DMA_RX] && ({1'b0, rxLevel} >= rxDmaLimit);
endmodule

// File: rtl/spi_fifo_flag_ctrl.sv
module spi_fifo_flag_ctrl
  import spiflag_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             engineBusy,
  input  logic             slaveTxBusy,
  input  logic             clrWr,
  input  logic [3:0]       clrData,
  input  logic [LVL_W-1:0] rxThresh,
  input  logic [LVL_W-1:0] txDmaThresh,
  input  logic [LVL_W-1:0] rxDmaThresh,
  input  logic [4:0]       intMask,
  input  logic [1:0]       dmaEn,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic [5:0]       status,
  output logic [4:0]       rawInt,
  output logic [4:0]       maskedInt,
  output logic             irq,
  output logic             txDmaReq,
  output logic             rxDmaReq
);
  fifoStrobes_t     strb;
  logic             txFull, txEmpty, rxFull, rxEmpty;
  logic [STK_N-1:0] sticky;

  spiflag_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .enable     (enable),
    .txPush     (txPush),
    .txPop      (txPop),
    .rxPush     (rxPush),
    .rxPop      (rxPop),
    .engineBusy (engineBusy),
    .slaveTxBusy(slaveTxBusy),
    .clrWr      (clrWr),
    .clrData    (clrData),
    .rxThresh   (rxThresh),
    .txDmaThresh(txDmaThresh),
    .rxDmaThresh(rxDmaThresh),
    .intMask    (intMask),
    .dmaEn      (dmaEn),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .txFull     (txFull),
    .txEmpty    (txEmpty),
    .rxFull     (rxFull),
    .rxEmpty    (rxEmpty),
    .sticky     (sticky),
    .strb       (strb),
    .status     (status),
    .rawInt     (rawInt),
    .maskedInt  (maskedInt),
    .irq        (irq),
    .txDmaReq   (txDmaReq),
    .rxDmaReq   (rxDmaReq)
  );

  spiflag_datapath #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .txLevel(txLevel),
    .rxLevel(rxLevel),
    .txFull (txFull),
    .txEmpty(txEmpty),
    .rxFull (rxFull),
    .rxEmpty(rxEmpty),
    .sticky (sticky)
  );
endmodule

// File: rtl/spiflag_checker.sv
module spiflag_checker #(
  parameter  int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             txPush,
  input logic             txPop,
  input logic             rxPush,
  input logic             rxPop,
  input logic             clrWr,
  input logic [3:0]       clrData,
  input logic [4:0]       intMask,
  input logic [1:0]       dmaEn,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic [4:0]       rawInt,
  input logic             irq,
  input logic             txDmaReq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= FULL_LVL) && (rxLevel <= FULL_LVL));

  // R1
  tx_push_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txPush && !txPop && txLevel < FULL_LVL)
      |=> (txLevel == $past(txLevel) + LVL_W'(1)));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && rxPush && !rxPop && rxLevel == FULL_LVL) |=> (rxLevel == FULL_LVL));

  // R3
  tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txPush && txLevel == FULL_LVL) |=> rawInt[1]);

  // R3
  tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawInt[1] && !(clrWr && (clrData[0] || clrData[3]))) |=> rawInt[1]);

  // R4
  rx_udf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && clrData[1] && !(enable && rxPop && rxLevel == '0)) |=> !rawInt[2]);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((rawInt & intMask) != 5'b0));

  // R8
  tx_dma_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> (enable && dmaEn[1]));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txLevel == '0) && (rxLevel == '0));
endmodule

bind spi_fifo_flag_ctrl spiflag_checker #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .txPush  (txPush),
  .txPop   (txPop),
  .rxPush  (rxPush),
  .rxPop   (rxPop),
  .clrWr   (clrWr),
  .clrData (clrData),
  .intMask (intMask),
  .dmaEn   (dmaEn),
  .txLevel (txLevel),
  .rxLevel (rxLevel),
  .rawInt  (rawInt),
  .irq     (irq),
  .txDmaReq(txDmaReq)
);

// File: tb/test_spi_fifo_flag_ctrl.sv
module test_spi_fifo_flag_ctrl;
  localparam int D  = 8;
  localparam int LW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic          engineBusy = 1'b0, slaveTxBusy = 1'b0;
  logic          clrWr = 1'b0;
  logic [3:0]    clrData = '0;
  logic [LW-1:0] rxThresh = '0, txDmaThresh = '0, rxDmaThresh = '0;
  logic [4:0]    intMask = '0;
  logic [1:0]    dmaEn = '0;
  logic [LW-1:0] txLevel, rxLevel;
  logic [5:0]    status;
  logic [4:0]    rawInt, maskedInt;
  logic          irq, txDmaReq, rxDmaReq;

  spi_fifo_flag_ctrl #(.DEPTH(D)) i_spi_fifo_flag_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .engineBusy(engineBusy), .slaveTxBusy(slaveTxBusy),
    .clrWr(clrWr), .clrData(clrData),
    .rxThresh(rxThresh), .txDmaThresh(txDmaThresh), .rxDmaThresh(rxDmaThresh),
    .intMask(intMask), .dmaEn(dmaEn),
    .txLevel(txLevel), .rxLevel(rxLevel), .status(status),
    .rawInt(rawInt), .maskedInt(maskedInt), .irq(irq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  always #5 clk = ~clk;

  int    nChecks = 0;
  int    nErrors = 0;
  bit    done = 1'b0;
  string phase = "reset";

  // Reference state
  int mTx = 0, mRx = 0;
  bit mTxOvf = 0, mRxOvf = 0, mRxUdf = 0;

  task automatic chk(input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s / %s: actual=%0d expected=%0d", phase, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit en = enable;
    if (clrWr) begin
      if (clrData[0] || clrData[3]) mTxOvf = 0;
      if (clrData[0] || clrData[2]) mRxOvf = 0;
      if (clrData[0] || clrData[1]) mRxUdf = 0;
    end
    if (!en) begin
      mTx = 0;
      mRx = 0;
    end else begin
      int nTx = mTx, nRx = mRx;
      if (txPush && mTx == D) mTxOvf = 1;
      if (rxPush && mRx == D) mRxOvf = 1;
      if (rxPop && mRx == 0)  mRxUdf = 1;
      if (txPush && mTx < D) nTx++;
      if (txPop && mTx > 0)  nTx--;
      if (rxPush && mRx < D) nRx++;
      if (rxPop && mRx > 0)  nRx--;
      mTx = nTx;
      mRx = nRx;
    end
  endtask

  task automatic checkAll();
    int expRaw, expSt;
    expRaw = ((mTx == 0) ? 1 : 0) | (mTxOvf << 1) | (mRxUdf << 2) | (mRxOvf << 3)
           | (((mRx > int'(rxThresh)) ? 1 : 0) << 4);
    expSt  = ((enable && (engineBusy || mTx != 0)) ? 1 : 0)
           | (((mTx == D) ? 1 : 0) << 1) | (((mTx == 0) ? 1 : 0) << 2)
           | (((mRx == 0) ? 1 : 0) << 3) | (((mRx == D) ? 1 : 0) << 4)
           | (((enable && slaveTxBusy) ? 1 : 0) << 5);
    chk("R1 tx level", int'(txLevel), mTx);
    chk("R1 rx level", int'(rxLevel), mRx);
    chk("R3 R4 sticky tx overflow", int'(rawInt[1]), int'(mTxOvf));
    chk("R3 R4 sticky rx underflow", int'(rawInt[2]), int'(mRxUdf));
    chk("R3 R4 sticky rx overflow", int'(rawInt[3]), int'(mRxOvf));
    chk("R5 level sources", int'({rawInt[4], rawInt[0]}), ((expRaw >> 3) & 2) | (expRaw & 1));
    chk("R6 masked", int'(maskedInt), expRaw & int'(intMask));
    chk("R6 irq", int'(irq), ((expRaw & int'(intMask)) != 0) ? 1 : 0);
    chk("R7 status", int'(status), expSt);
    chk("R8 tx dma", int'(txDmaReq),
        (enable && dmaEn[1] && mTx <= int'(txDmaThresh)) ? 1 : 0);
    chk("R9 rx dma", int'(rxDmaReq),
        (enable && dmaEn[0] && mRx >= int'(rxDmaThresh) + 1) ? 1 : 0);
  endtask

  // One clock: inputs were set on the falling edge, result checked on the next one
  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkAll();
    txPush = 0; txPop = 0; rxPush = 0; rxPop = 0; clrWr = 0; clrData = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkAll();                       // reset state
    rstN = 1'b1;
    @(negedge clk);
    checkAll();

    enable = 1; intMask = 5'h1f; dmaEn = 2'b11;
    rxThresh = 3; txDmaThresh = 2; rxDmaThresh = 4;

    phase = "R1 R2 R3 tx fill past full";
    for (int i = 0; i < D + 2; i++) begin txPush = 1; step(); end
    phase = "R4 clear tx overflow via bit 3";
    clrWr = 1; clrData = 4'b1000; step();
    phase = "R2 tx drain past empty sets nothing";
    for (int i = 0; i < D + 2; i++) begin txPop = 1; step(); end

    phase = "R1 R3 rx fill past full";
    for (int i = 0; i < D + 1; i++) begin rxPush = 1; step(); end
    phase = "R2 R3 rx drain past empty";
    for (int i = 0; i < D + 2; i++) begin rxPop = 1; step(); end
    phase = "R4 clear all via bit 0";
    clrWr = 1; clrData = 4'b0001; step();

    phase = "R2 simultaneous push and pop at empty";
    txPush = 1; txPop = 1; rxPush = 1; rxPop = 1; step();
    phase = "R1 simultaneous push and pop mid level";
    txPush = 1; txPop = 1; rxPush = 1; rxPop = 1; step();
    for (int i = 0; i < D; i++) begin txPush = 1; rxPush = 1; step(); end
    phase = "R2 simultaneous push and pop at full";
    txPush = 1; txPop = 1; rxPush = 1; rxPop = 1; step();

    phase = "R4 set wins over same-cycle clear";
    txPush = 1; step(); rxPush = 1; step();
    rxPush = 1; txPush = 1; clrWr = 1; clrData = 4'b1100; step();
    clrWr = 1; clrData = 4'b0100; step();
    clrWr = 1; clrData = 4'b1000; step();
    for (int i = 0; i < D; i++) begin rxPop = 1; step(); end
    rxPop = 1; step();
    clrWr = 1; clrData = 4'b0010; step();

    phase = "R10 disable flushes and keeps sticky";
    txPush = 1; rxPush = 1; step();
    txPush = 1; clrWr = 0; step();
    enable = 0;
    for (int i = 0; i < 3; i++) begin txPush = 1; rxPush = 1; rxPop = 1; step(); end
    engineBusy = 1; slaveTxBusy = 1; step();
    clrWr = 1; clrData = 4'b0001; step();
    enable = 1;
    phase = "R7 busy inputs while enabled";
    step();
    engineBusy = 0; step();
    txPush = 1; step();
    slaveTxBusy = 0; txPop = 1; step();

    phase = "R5 R8 R9 level by threshold sweep";
    for (int lvl = 0; lvl <= D; lvl++) begin
      if (lvl > 0) begin txPush = 1; rxPush = 1; step(); end
      for (int t = 0; t <= D; t++) begin
        rxThresh = LW'(t); txDmaThresh = LW'(t); rxDmaThresh = LW'(t);
        step();
      end
    end

    phase = "R8 R9 dma enable combinations";
    rxDmaThresh = 2; txDmaThresh = D;
    for (int e = 0; e < 4; e++) begin dmaEn = 2'(e); step(); end

    phase = "R6 mask sweep";
    rxPush = 1; step();
    rxThresh = 2;
    for (int m = 0; m < 32; m++) begin intMask = 5'(m); step(); end
    for (int i = 0; i < D; i++) begin txPop = 1; step(); end
    for (int m = 0; m < 32; m++) begin intMask = 5'(m); step(); end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule